// File: doc/BRIEF.md
# Rotation-Aligned Core Clock Skipper

This block produces one clock-enable line for each of the processor cores that share a round-robin hub. The hub grants one slot per system clock and completes a rotation after as many clocks as there are cores. A rotation is the unit of time here. Each core has a skip count. When the count is zero, the core is enabled on every clock. When the count is non-zero, the core is enabled for one whole rotation and then held for that many whole rotations. This pattern repeats.

Every decision is made at the rotation boundary, which is the clock edge at which the hub slot counter reads 0. A run or a sleep therefore always covers complete hub rotations. The system clock keeps its full rate, and the hub goes on cycling through every slot. A sleeping core leaves its slots unused, and its state is preserved because no enable reaches it. Each core keeps its own count of remaining idle rotations, so each core can run at its own duty ratio. The enables feed the clock-gating cells, which sit outside this block.

Top module: `rot_clk_skipper`

## Requirements
- R1: When reset is high at a clock edge, every `core_en` bit is 1 after that edge. All bits stay 1 until the first rotation boundary after reset.
- R2: If a core's skip count is 0 at a rotation boundary, its `core_en` bit is 1 for the whole following rotation. This applies even when the core was in the middle of a sleep.
- R3: `core_en` changes only on a clock edge at which `hub_slot` reads 0. At every other edge it holds its value.
- R4: The skip count of core i is `skip_cnt[8*i+7 : 8*i]`. A core with a constant non-zero count N is enabled for 16 clocks and then disabled for N×16 clocks, and this repeats.
- R5: Each core follows its own skip count and its own idle-rotation count, independently of the other cores.
- R6: The skip count is sampled only at a rotation boundary. A change made in the middle of a rotation does not affect `core_en` before the next boundary.
- R7: Suppose a core would sleep at a boundary, but its remaining idle rotations exceed its current skip count N. The remaining count is then cut down to N: the core sleeps this rotation and then N−1 more before it runs.
- R8: A skip count of 255 yields exactly 255×16 = 4080 consecutive disabled clocks between runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hub_slot | input | 4 | Free-running hub slot counter; 0 marks the rotation boundary |
| skip_cnt | input | 128 | Skip counts, 8 bits per core; core i uses bits 8i+7..8i |
| core_en | output | 16 | Registered per-core clock enable |

## Verification
The assertions check three things on every cycle:
- the enables stay constant between boundaries (R3);
- all enables are on just after reset (R1);
- a zero skip count at a boundary always yields a run (R2).

They also check that a core that has just run, and whose count is unchanged and non-zero, goes to sleep at the next boundary (R4).

The full length of each sleep depends on a count that can span hundreds of rotations, so only the bench scenarios can show it. The same holds for the clamping when the count shrinks during a sleep (R7), and for cores at different counts staying independent (R5). For these the bench compares against its reference model on every clock, and it measures the 255-rotation gap directly.

// File: rtl/skip_pkg.sv
package skip_pkg;
  localparam int DEF_CORES  = 16;
  localparam int DEF_SKIP_W = 8;

  typedef enum logic {
    LANE_IDLE = 1'b0,
    LANE_RUN  = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/rot_boundary.sv
module rot_boundary #(
  parameter int SLOT_W = 4
) (
  input  logic [SLOT_W-1:0] hub_slot,
  output logic              at_bnd
);
  assign at_bnd = (hub_slot == '0);
endmodule

// File: rtl/skip_lane.sv
module skip_lane
  import skip_pkg::*;
#(
  parameter int SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              at_bnd,
  input  logic [SKIP_W-1:0] skip,
  output logic              en
);
  lane_mode_e        mode_q;
  logic [SKIP_W-1:0] idle_q;
  logic [SKIP_W-1:0] idle_eff;
  logic              start_run;

  // remaining idle rotations never exceed the count now in force
  assign idle_eff  = (idle_q > skip) ? skip : idle_q;
  assign start_run = (skip == '0) || (idle_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= LANE_RUN;
      idle_q <= '0;
    end else if (at_bnd) begin
      if (start_run) begin
        mode_q <= LANE_RUN;
        idle_q <= skip;
      end else begin
        mode_q <= LANE_IDLE;
        idle_q <= idle_eff - 1'b1;
      end
    end
  end

  assign en = (mode_q == LANE_RUN);
endmodule

// File: rtl/rot_clk_skipper.sv
module rot_clk_skipper
  import skip_pkg::*;
#(
  parameter int NUM_CORES = DEF_CORES,
  parameter int SKIP_W    = DEF_SKIP_W,
  localparam int SLOT_W   = $clog2(NUM_CORES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SLOT_W-1:0]           hub_slot,
  input  logic [NUM_CORES*SKIP_W-1:0] skip_cnt,
  output logic [NUM_CORES-1:0]        core_en
);
  logic at_bnd;

  rot_boundary #(.SLOT_W(SLOT_W)) u_bnd (
    .hub_slot (hub_slot),
    .at_bnd   (at_bnd)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_lane
    skip_lane #(.SKIP_W(SKIP_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .at_bnd (at_bnd),
      .skip   (skip_cnt[i*SKIP_W +: SKIP_W]),
      .en     (core_en[i])
    );
  end
endmodule

// File: rtl/rot_clk_skipper_chk.sv
module rot_clk_skipper_chk #(
  parameter int NUM_CORES = 16,
  parameter int SKIP_W    = 8,
  parameter int SLOT_W    = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic [SLOT_W-1:0]           hub_slot,
  input logic [NUM_CORES*SKIP_W-1:0] skip_cnt,
  input logic [NUM_CORES-1:0]        core_en
);
  logic [SKIP_W-1:0] prev_skip [NUM_CORES];

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_CORES; k++) begin
      if (rst) prev_skip[k] <= '0;
      else if (hub_slot == '0) prev_skip[k] <= skip_cnt[k*SKIP_W +: SKIP_W];
    end
  end

  AST_RESET_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&core_en)); // R1

  AST_HOLD_MID_ROT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hub_slot) != '0) |-> $stable(core_en)); // R3

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
    AST_ZERO_SKIP_RUNS: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(hub_slot) == '0 &&
       $past(skip_cnt[i*SKIP_W +: SKIP_W]) == '0) |-> core_en[i]); // R2

    AST_RUN_THEN_SLEEP: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(hub_slot) == '0 && $past(core_en[i]) &&
       $past(skip_cnt[i*SKIP_W +: SKIP_W]) != '0 &&
       $past(skip_cnt[i*SKIP_W +: SKIP_W]) == $past(prev_skip[i])) |-> !core_en[i]); // R4
  end
endmodule

bind rot_clk_skipper rot_clk_skipper_chk #(
  .NUM_CORES (NUM_CORES),
  .SKIP_W    (SKIP_W),
  .SLOT_W    (SLOT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .hub_slot (hub_slot),
  .skip_cnt (skip_cnt),
  .core_en  (core_en)
);

// File: tb/tb_rot_clk_skipper.sv
`timescale 1ns/1ps
module tb_rot_clk_skipper;
  localparam int NC = 16;
  localparam int SW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [3:0]      hub_slot = 4'd5;
  logic [NC*SW-1:0] skip_cnt = '0;
  logic [NC-1:0]   core_en;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  rot_clk_skipper dut (
    .clk(clk), .rst(rst), .hub_slot(hub_slot), .skip_cnt(skip_cnt), .core_en(core_en)
  );

  always #5 clk = ~clk;

  always @(negedge clk) hub_slot <= hub_slot + 4'd1;

  // behavioural reference model
  int          m_idle [NC];
  bit [NC-1:0] m_en;
  bit          mv = 0;
  int          edge_slot;
  bit          edge_rst;

  always @(posedge clk) begin
    edge_slot = hub_slot;
    edge_rst  = rst;
    if (rst) begin
      m_en = '1;
      foreach (m_idle[i]) m_idle[i] = 0;
    end else if (hub_slot == 0) begin
      for (int i = 0; i < NC; i++) begin
        int n;
        n = skip_cnt[i*SW +: SW];
        if (n == 0 || m_idle[i] == 0) begin
          m_en[i] = 1'b1; m_idle[i] = n;
        end else begin
          m_en[i] = 1'b0;
          m_idle[i] = ((m_idle[i] > n) ? n : m_idle[i]) - 1;
        end
      end
    end
    mv = 1;
  end

  task automatic check(input string req, input logic [NC-1:0] act, input logic [NC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: core_en=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  logic [NC-1:0] last_en;
  bit            have_last = 0;

  always @(negedge clk) begin
    if (mv) begin
      check(cur_req, core_en, m_en);
      if (have_last && !edge_rst && edge_slot != 0)
        check("R3", core_en, last_en);
      last_en   = core_en;
      have_last = 1;
    end
  end

  task automatic set_skip(input int core, input int val);
    skip_cnt[core*SW +: SW] = val[SW-1:0];
  endtask

  task automatic wait_slot(input int s);
    do begin @(negedge clk); #1; end while (hub_slot != s[3:0]);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1", core_en, '1);

    cur_req = "R2";
    repeat (48) @(negedge clk);

    // distinct counts per core: R4 and R5
    cur_req = "R5";
    wait_slot(3);
    for (int i = 0; i < NC; i++) set_skip(i, i % 6);
    repeat (16 * 30) @(negedge clk);
    cur_req = "R4";
    for (int i = 0; i < NC; i++) set_skip(i, 2);
    repeat (16 * 12) @(negedge clk);

    // mid-rotation change has no effect before boundary: R6
    cur_req = "R6";
    for (int i = 0; i < NC; i++) set_skip(i, 0);
    repeat (40) @(negedge clk);
    wait_slot(8);
    set_skip(0, 4);
    wait_slot(15);
    check("R6", {15'd0, core_en[0]}, {15'd0, 1'b1});
    repeat (16 * 12) @(negedge clk);

    // shrink count while sleeping: R7
    cur_req = "R7";
    set_skip(1, 10);
    repeat (16 * 14) @(negedge clk);
    wait_slot(6);
    while (core_en[1]) wait_slot(6);
    set_skip(1, 2);
    repeat (16 * 10) @(negedge clk);

    // wake from sleep with zero count: R2
    cur_req = "R2";
    set_skip(2, 15);
    repeat (16 * 4) @(negedge clk);
    set_skip(2, 0);
    repeat (16 * 3) @(negedge clk);

    // maximum count: R8
    cur_req = "R8";
    set_skip(3, 255);
    while (!core_en[3]) @(negedge clk);
    while (core_en[3]) @(negedge clk);
    gap = 0;
    while (!core_en[3]) begin gap++; @(negedge clk); end
    checks++;
    if (gap != 255 * 16) begin
      errors++;
      $display("FAIL R8: idle gap=%0d expected %0d", gap, 255 * 16);
    end
    repeat (40) @(negedge clk);

    finish_run();
  end
endmodule